// File: doc/BRIEF.md
# Keyed-Unlock Watchdog Timer

This block is a bus-attached watchdog. A two-stage counter runs from the bus clock. A 16-bit prescaler produces ticks, and a 16-bit down counter consumes them. When the down counter runs out while the watchdog is enabled, the block drives a one-clock reset pulse and then reloads. Software has to restart the countdown on a regular basis, and a missed restart ends in a reset.

Every control value sits behind a lock of its own. A lock is a register that accepts an exact series of key words. It reports in its low two bits how far the series has got. A control write counts only while its lock shows full progress, and that write locks the register again. Any write that is not the expected key sends the lock back to zero, and this includes a write to any other register.

Top module: `wdk_top`

## Requirements
- R1: After reset every lock reads 0, the enable register reads 0, the reload value reads 0xFFFF, the prescale value reads 0xFFFF and `wd_rst_o` is low.
- R2: The restart lock (word 0) opens with 0x00005555 and then 0x0000AAAA. Its status reads 1 after the first key and 3 after the second.
- R3: The reload lock (word 2) opens with 0x00006666 and then 0x0000BBBB. The prescale lock (word 6) opens with 0x00005A5A and then 0x0000A5A5. Each reports 1 and then 3.
- R4: The enable lock (word 4) takes three keys: 0x00007777, 0x0000CCCC and 0x0000DDDD. Its status reads 1, 2 and then 3. A two-key lock never reports 2.
- R5: A write of any other value to a lock, or a write to any other word, sets that lock's status to 0. One accepted control write also sets it back to 0.
- R6: A write to a control word (1, 3, 5 or 7) whose lock does not read 3 is ignored, and the stored value keeps its old contents.
- R7: Bit 0 of the enable word (word 5) enables the watchdog when 1 and disables it when 0. While disabled, `wd_rst_o` stays low.
- R8: The reload (word 3) and prescale (word 7) values keep bits 15:0 of the write. A reload write of 0 is stored as 1.
- R9: Once enabled, the first pulse appears reload × prescale clocks after the enabling write. A prescale of 0 counts as 1.
- R10: Each pulse lasts one clock. The counter then reloads, and the next pulse follows after the same interval.
- R11: An accepted write to the restart word (word 1) with bit 0 set restarts the full interval from that write. With bit 0 clear it changes nothing.
- R12: Word order is 0 restart lock, 1 restart, 2 reload lock, 3 reload, 4 enable lock, 5 enable, 6 prescale lock, 7 prescale. A lock reads its status in bits 1:0 with the upper bits zero. Word 1 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| wd_rst_o | output | 1 | Watchdog reset pulse |

## Verification
The locks are driven with the correct key series, with a correct first key followed by a stray value, and with a correct first key followed by a write to another word. These three patterns separate key matching from the clear-on-any-other-write rule. Intervals are measured for a directed reload and prescale pair and then for random pairs. This exposes any off-by-one in either stage, because the product only comes out right when both stages count exactly. The bench also measures a restart in mid-interval, a restart write with bit 0 clear, and the disabled state, to show that only a real restart moves the deadline.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int AW = 3;
  localparam int DW = 32;
  localparam int VW = 16;
  localparam int NLOCK = 4;

  // lock index: 0 restart, 1 reload, 2 enable, 3 prescale
  function automatic logic [15:0] key_of(int g, int k);
    logic [15:0] r;
    r = 16'h0;
    case (g)
      0: r = (k == 0) ? 16'h5555 : 16'hAAAA;
      1: r = (k == 0) ? 16'h6666 : 16'hBBBB;
      2: r = (k == 0) ? 16'h7777 : (k == 1) ? 16'hCCCC : 16'hDDDD;
      default: r = (k == 0) ? 16'h5A5A : 16'hA5A5;
    endcase
    return r;
  endfunction

  function automatic int nkeys_of(int g);
    return (g == 2) ? 3 : 2;
  endfunction
endpackage

// File: rtl/wdk_lock.sv
module wdk_lock #(
  parameter int          AW        = 3,
  parameter int          DW        = 32,
  parameter int          NKEYS     = 2,
  parameter logic [15:0] KEY0      = 16'h0,
  parameter logic [15:0] KEY1      = 16'h0,
  parameter logic [15:0] KEY2      = 16'h0,
  parameter logic [2:0]  LOCK_ADDR = 3'd0,
  parameter logic [2:0]  DATA_ADDR = 3'd1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [1:0]    stat_o,
  output logic          grant_o
);
  localparam logic [1:0] NK = 2'(NKEYS);

  logic [1:0]  st_q, st_d;
  logic [15:0] key_sel;
  logic        hit;

  always_comb begin
    case (st_q)
      2'd0:    key_sel = KEY0;
      2'd1:    key_sel = KEY1;
      default: key_sel = KEY2;
    endcase
  end

  assign hit     = wr_i && (addr_i == LOCK_ADDR) && (st_q < NK)
                   && (wdata_i == {{(DW-16){1'b0}}, key_sel});
  assign grant_o = wr_i && (addr_i == DATA_ADDR) && (st_q == NK);
  assign st_d    = !wr_i ? st_q : (hit ? st_q + 2'd1 : 2'd0);
  assign stat_o  = (st_q == NK) ? 2'd3 : st_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= 2'd0;
    else         st_q <= st_d;

  // R5: a write elsewhere always re-locks
  p_lock_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && (addr_i != LOCK_ADDR) |=> stat_o == 2'd0);

  generate
    if (NKEYS == 2) begin : g_two
      // R4: two-key locks skip status 2
      p_status_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_o != 2'd2);
    end
  endgenerate
endmodule

// File: rtl/wdk_timer.sv
module wdk_timer #(
  parameter int VW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          kick_i,
  input  logic [VW-1:0] reload_i,
  input  logic [VW-1:0] presc_i,
  output logic          expire_o
);
  localparam logic [VW-1:0] ONE = VW'(1);

  logic [VW-1:0] pre_q, cnt_q;
  logic          exp_q, tick;

  // prescale of 0 or 1 ticks every clock; >= guards a lowered prescale
  assign tick = (presc_i <= ONE) || (pre_q >= presc_i - ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '1;
      exp_q <= 1'b0;
    end else if (!en_i || kick_i) begin
      pre_q <= '0;
      cnt_q <= reload_i;
      exp_q <= 1'b0;
    end else if (tick) begin
      pre_q <= '0;
      if (cnt_q <= ONE) begin
        cnt_q <= reload_i;
        exp_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - ONE;
        exp_q <= 1'b0;
      end
    end else begin
      pre_q <= pre_q + ONE;
      exp_q <= 1'b0;
    end
  end

  assign expire_o = exp_q;

  p_no_pulse_disabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !expire_o);

  p_cnt_nonzero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != '0);

  p_pulse_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o && !((reload_i == ONE) && (presc_i <= ONE)) && !kick_i |=> !expire_o);
endmodule

// File: rtl/wdk_top.sv
module wdk_top
  import wdk_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_en_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          wd_rst_o
);
  logic             wr;
  logic [1:0]       stat [NLOCK];
  logic [NLOCK-1:0] grant;
  logic             en_q;
  logic [VW-1:0]    chg_q, pre_q;
  logic             kick;

  assign wr = bus_en_i && bus_we_i;

  for (genvar g = 0; g < NLOCK; g++) begin : g_lock
    wdk_lock #(
      .AW(AW), .DW(DW), .NKEYS(nkeys_of(g)),
      .KEY0(key_of(g, 0)), .KEY1(key_of(g, 1)), .KEY2(key_of(g, 2)),
      .LOCK_ADDR(3'(2*g)), .DATA_ADDR(3'(2*g+1))
    ) i_lock (
      .clk_i, .rst_ni, .wr_i(wr), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
      .stat_o(stat[g]), .grant_o(grant[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      chg_q <= '1;
      pre_q <= '1;
    end else begin
      if (grant[1]) chg_q <= (bus_wdata_i[VW-1:0] == '0) ? VW'(1) : bus_wdata_i[VW-1:0];
      if (grant[2]) en_q  <= bus_wdata_i[0];
      if (grant[3]) pre_q <= bus_wdata_i[VW-1:0];
    end
  end

  assign kick = grant[0] && bus_wdata_i[0];

  always_comb begin
    if (!bus_addr_i[0]) bus_rdata_o = {{(DW-2){1'b0}}, stat[bus_addr_i[2:1]]};
    else begin
      case (bus_addr_i[2:1])
        2'd1:    bus_rdata_o = {{(DW-VW){1'b0}}, chg_q};
        2'd2:    bus_rdata_o = {{(DW-1){1'b0}}, en_q};
        2'd3:    bus_rdata_o = {{(DW-VW){1'b0}}, pre_q};
        default: bus_rdata_o = '0;
      endcase
    end
  end

  wdk_timer #(.VW(VW)) i_timer (
    .clk_i, .rst_ni, .en_i(en_q), .kick_i(kick),
    .reload_i(chg_q), .presc_i(pre_q), .expire_o(wd_rst_o)
  );

  // R6: stored values move only out of a fully open lock
  p_chg_unlock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(chg_q) |-> $past(stat[1]) == 2'd3);
  p_en_unlock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(en_q) |-> $past(stat[2]) == 2'd3);
  p_pre_unlock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pre_q) |-> $past(stat[3]) == 2'd3);
endmodule

// File: tb/test_wdk_top.sv
module test_wdk_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_en_i = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [2:0]  bus_addr_i = 3'd0;
  logic [31:0] bus_wdata_i = 32'd0;
  logic [31:0] bus_rdata_o;
  logic        wd_rst_o;

  int total = 0, bad = 0, cyc = 0;

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  wdk_top i_wdk_top (.*);

  function automatic logic [31:0] key_f(int g, int k);
    logic [15:0] t [4][3];
    t[0] = '{16'h5555, 16'hAAAA, 16'h0};
    t[1] = '{16'h6666, 16'hBBBB, 16'h0};
    t[2] = '{16'h7777, 16'hCCCC, 16'hDDDD};
    t[3] = '{16'h5A5A, 16'hA5A5, 16'h0};
    return {16'h0, t[g][k]};
  endfunction

  function automatic int period_f(int c, int p);
    return c * ((p == 0) ? 1 : p);
  endfunction

  function automatic logic [31:0] chg_f(logic [31:0] w);
    return (w[15:0] == 16'h0) ? 32'd1 : {16'h0, w[15:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    bus_en_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_en_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    bus_en_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    bus_en_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic unlock(int g);
    for (int k = 0; k < ((g == 2) ? 3 : 2); k++) wr(3'(2*g), key_f(g, k));
  endtask

  task automatic set_reg(int g, logic [31:0] d);
    unlock(g);
    wr(3'(2*g+1), d);
  endtask

  // wait for pulse; returns clocks since t0
  task automatic wait_pulse(int t0, int lim, output int n);
    int s = cyc;
    while (!wd_rst_o && (cyc - s) < lim) @(negedge clk_i);
    n = wd_rst_o ? cyc - t0 : -1;
  endtask

  initial begin
    logic [31:0] d;
    int n, t0, seen;
    void'($urandom(1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1, R12 reset values and map
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      case (a)
        3: chk("R1 reload", d, 32'hFFFF);
        7: chk("R1 prescale", d, 32'hFFFF);
        default: chk("R1 R12 word", d, 32'h0);
      endcase
    end
    chk("R1 wd_rst", 32'(wd_rst_o), 32'd0);

    // R2
    wr(3'd0, 32'h5555); rd(3'd0, d); chk("R2 step1", d, 32'd1);
    wr(3'd0, 32'hAAAA); rd(3'd0, d); chk("R2 step2", d, 32'd3);
    wr(3'd1, 32'd1);    rd(3'd0, d); chk("R5 rearm after data", d, 32'd0);
    rd(3'd1, d); chk("R12 restart reads 0", d, 32'd0);

    // R3 and R8
    wr(3'd2, 32'h6666); rd(3'd2, d); chk("R3 reload step1", d, 32'd1);
    wr(3'd2, 32'hBBBB); rd(3'd2, d); chk("R3 reload step2", d, 32'd3);
    wr(3'd3, 32'h0001_2345); rd(3'd3, d); chk("R8 reload low bits", d, 32'h2345);
    wr(3'd6, 32'h5A5A); rd(3'd6, d); chk("R3 prescale step1", d, 32'd1);
    wr(3'd6, 32'hA5A5); rd(3'd6, d); chk("R3 prescale step2", d, 32'd3);
    wr(3'd7, 32'hFFFF_0007); rd(3'd7, d); chk("R8 prescale low bits", d, 32'd7);
    set_reg(1, 32'h0); rd(3'd3, d); chk("R8 reload zero clamps", d, 32'd1);

    // R4
    wr(3'd4, 32'h7777); rd(3'd4, d); chk("R4 step1", d, 32'd1);
    wr(3'd4, 32'hCCCC); rd(3'd4, d); chk("R4 step2", d, 32'd2);
    wr(3'd4, 32'hDDDD); rd(3'd4, d); chk("R4 step3", d, 32'd3);
    wr(3'd5, 32'd0); rd(3'd5, d); chk("R7 stays disabled", d, 32'd0);

    // R5 wrong key and foreign write
    wr(3'd0, 32'h5555); wr(3'd0, 32'h1234); rd(3'd0, d); chk("R5 wrong key", d, 32'd0);
    wr(3'd0, 32'h5555); wr(3'd2, 32'h6666); rd(3'd0, d); chk("R5 foreign write", d, 32'd0);
    rd(3'd2, d); chk("R2 R3 other lock advanced", d, 32'd1);
    wr(3'd0, 32'h0001_5555); rd(3'd0, d); chk("R5 upper bits not zero", d, 32'd0);

    // R6 locked writes ignored
    wr(3'd3, 32'h0042); rd(3'd3, d); chk("R6 locked reload", d, 32'd1);
    wr(3'd2, 32'h6666); wr(3'd3, 32'h0042); rd(3'd3, d); chk("R6 partly open reload", d, 32'd1);
    wr(3'd5, 32'd1); rd(3'd5, d); chk("R6 locked enable", d, 32'd0);
    wr(3'd4, 32'h7777); wr(3'd4, 32'hCCCC); wr(3'd5, 32'd1);
    rd(3'd5, d); chk("R6 two of three keys", d, 32'd0);

    // R9, R10 directed: reload 4, prescale 3
    set_reg(1, 32'd4); set_reg(3, 32'd3);
    set_reg(2, 32'd1); t0 = cyc;
    wait_pulse(t0, 200, n); chk("R9 first interval", n, 32'd12);
    @(negedge clk_i); chk("R10 one clock wide", 32'(wd_rst_o), 32'd0);
    t0 = cyc - 1;
    wait_pulse(t0, 200, n); chk("R10 repeat interval", n, 32'd12);

    // R7 disable
    set_reg(2, 32'd0);
    seen = 0;
    repeat (40) begin @(negedge clk_i); if (wd_rst_o) seen = 1; end
    chk("R7 no pulse disabled", seen, 32'd0);

    // R11 restart mid-interval, and restart with bit 0 clear
    set_reg(1, 32'd5); set_reg(3, 32'd4);
    set_reg(2, 32'd1); t0 = cyc;
    repeat (6) @(negedge clk_i);
    set_reg(0, 32'd0);
    wait_pulse(t0, 200, n); chk("R11 bit0 clear no restart", n, 32'd20);
    repeat (3) @(negedge clk_i);
    set_reg(0, 32'd1); t0 = cyc;
    wait_pulse(t0, 200, n); chk("R11 restart full interval", n, 32'd20);

    // R9 random pairs
    for (int i = 0; i < 6; i++) begin
      int c = 2 + int'($urandom_range(0, 4));
      int p = int'($urandom_range(0, 4));
      set_reg(2, 32'd0);
      set_reg(1, 32'(c)); set_reg(3, 32'(p));
      set_reg(2, 32'd1); t0 = cyc;
      wait_pulse(t0, 200, n); chk("R9 random interval", n, 32'(period_f(c, p)));
      rd(3'd3, d); chk("R8 random reload", d, chg_f(32'(c)));
    end
    set_reg(2, 32'd0);

    // R5 random wrong second key
    for (int i = 0; i < 4; i++) begin
      logic [31:0] w = $urandom();
      if (w == key_f(1, 1)) w = w + 1;
      wr(3'd2, key_f(1, 0)); wr(3'd2, w);
      rd(3'd2, d); chk("R5 random wrong key", d, 32'd0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule